// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with One Delay Slot

This block owns the fetch program counter of a five-stage pipeline and settles conditional branches while they sit in the decode stage. Each cycle it looks at the instruction in decode: its kind, its source register number and forwarded value, a 16-bit immediate and a 26-bit jump offset. It chooses the next fetch address. A branch tests a single register against zero. Both the zero test and the target adder work in decode, so a branch costs one cycle. That cycle is filled by one architectural delay slot: the instruction fetched just behind the branch.

An ordinary branch always lets its slot instruction run. A canceling branch carries a static taken or not-taken guess. When the guess is wrong, the block raises a squash flag during the slot instruction's decode cycle. The pipeline then loads a bubble with write and memory enables cleared into the next register. If the register a branch tests is still being produced by the instruction in execute, the block stalls decode for one cycle before evaluating the branch.

Top module: `brnext_unit`

## Requirements
- R1: While reset is held, `fetch_pc` equals parameter `RESET_PC` and `squash_slot` is low.
- R2: When no redirect and no stall occur, `fetch_pc` advances by 4 on each clock.
- R3: `id_kind` encodes 2'b00 no control transfer, 2'b01 branch-if-zero, 2'b10 branch-if-not-zero, 2'b11 jump. A taken branch makes the next `fetch_pc` equal `id_pc + 4 + immediate`. Branch-if-zero is taken when `id_src_val` is zero, and branch-if-not-zero is taken when it is non-zero. A branch that is not taken lets `fetch_pc` advance by 4.
- R4: The 16-bit immediate is sign-extended from its bit 15, so a negative immediate moves the target below `id_pc + 4`.
- R5: A jump always redirects to `id_pc + 4 + id_off`, with the 26-bit offset sign-extended from bit 25. It never stalls and never squashes its slot, whatever the values of `id_cancel` and `id_pred_taken`.
- R6: A branch with `id_cancel` low never raises `squash_slot`.
- R7: For a branch with `id_cancel` high, `squash_slot` is high during the clock cycle after the branch is evaluated. It is high exactly when the outcome differs from `id_pred_taken`.
- R8: `stall` is high, in the same cycle and combinationally, for a conditional branch when `ex_wr_en` is high and `ex_wr_idx` equals a non-zero `id_src_idx`. During a stall, `fetch_pc` holds its value and `squash_slot` stays low on the next cycle. The branch is evaluated once the match clears.
- R9: An instruction in decode while `squash_slot` is high is ignored. It causes no redirect, no stall and no squash.
- R10: An instruction with `id_valid` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_pc | input | XLEN | Address of the instruction in decode |
| id_kind | input | 2 | Control-transfer kind of the decode instruction |
| id_cancel | input | 1 | Branch is of the canceling type |
| id_pred_taken | input | 1 | Static guess carried by a canceling branch |
| id_src_idx | input | RIDX_W | Register number tested by the branch |
| id_src_val | input | XLEN | Forwarded value of the tested register |
| id_imm | input | IMM_W | Branch immediate |
| id_off | input | OFF_W | Jump offset |
| ex_wr_en | input | 1 | Instruction in execute writes a register |
| ex_wr_idx | input | RIDX_W | Destination register of that instruction |
| fetch_pc | output | XLEN | Address to fetch next |
| stall | output | 1 | Hold fetch and decode, send a bubble to execute |
| squash_slot | output | 1 | Turn the decode instruction into a bubble |

## Verification
The only state is the fetch address register and the one-bit squash flag, so a fault shows at the ports one clock after the decode cycle that caused it. A wrong target or a wrong zero test gives an unexpected `fetch_pc` on the next edge. A misrouted squash flag shows as `squash_slot` set after a plain branch, left low after a wrong guess, or still set after a stall. Either fault also shows one cycle later, when the slot instruction is wrongly acted on or wrongly ignored. Stall errors appear in the same cycle on `stall` and on the next edge as a `fetch_pc` that moved when it should have held.

// File: rtl/brnext_pkg.sv
package brnext_pkg;

    typedef enum logic [1:0] {
        K_NONE = 2'b00,
        K_BEQZ = 2'b01,
        K_BNEZ = 2'b10,
        K_JUMP = 2'b11
    } bkind_e;

    localparam int unsigned INSN_BYTES = 4;

endpackage

// File: rtl/brnext_cond.sv
module brnext_cond
    import brnext_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  bkind_e            kind,
    input  logic [XLEN-1:0]   src_val,
    input  logic              cancel,
    input  logic              pred_taken,
    output logic              take,
    output logic              guess_miss
);
    logic is_zero;

    always_comb begin
        is_zero = ~|src_val;
        unique case (kind)
            K_BEQZ:  take = is_zero;
            K_BNEZ:  take = ~is_zero;
            default: take = 1'b0;
        endcase
        guess_miss = cancel && (take != pred_taken);
    end
endmodule

// File: rtl/brnext_target.sv
module brnext_target
    import brnext_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int OFF_W = 26
) (
    input  logic [XLEN-1:0]  id_pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [OFF_W-1:0] off,
    output logic [XLEN-1:0]  br_target,
    output logic [XLEN-1:0]  jmp_target
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] off_x;

    generate
        if (IMM_W < XLEN) begin : g_imm_ext
            assign imm_x = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        end else begin : g_imm_cut
            assign imm_x = imm[XLEN-1:0];
        end
        if (OFF_W < XLEN) begin : g_off_ext
            assign off_x = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
        end else begin : g_off_cut
            assign off_x = off[XLEN-1:0];
        end
    endgenerate

    logic [XLEN-1:0] seq_pc;

    always_comb begin
        seq_pc     = id_pc + STEP;
        br_target  = seq_pc + imm_x;
        jmp_target = seq_pc + off_x;
    end
endmodule

// File: rtl/brnext_hazard.sv
module brnext_hazard #(
    parameter int RIDX_W = 5
) (
    input  logic              is_cond,
    input  logic [RIDX_W-1:0] src_idx,
    input  logic              ex_wr_en,
    input  logic [RIDX_W-1:0] ex_wr_idx,
    output logic              hold
);
    logic same_reg;
    logic real_reg;

    always_comb begin
        same_reg = (src_idx == ex_wr_idx);
        real_reg = |src_idx;
        hold     = is_cond && ex_wr_en && same_reg && real_reg;
    end
endmodule

// File: rtl/brnext_unit.sv
module brnext_unit
    import brnext_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter int               IMM_W    = 16,
    parameter int               OFF_W    = 26,
    parameter int               RIDX_W   = 5,
    parameter logic [XLEN-1:0]  RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [XLEN-1:0]   id_pc,
    input  logic [1:0]        id_kind,
    input  logic              id_cancel,
    input  logic              id_pred_taken,
    input  logic [RIDX_W-1:0] id_src_idx,
    input  logic [XLEN-1:0]   id_src_val,
    input  logic [IMM_W-1:0]  id_imm,
    input  logic [OFF_W-1:0]  id_off,
    input  logic              ex_wr_en,
    input  logic [RIDX_W-1:0] ex_wr_idx,
    output logic [XLEN-1:0]   fetch_pc,
    output logic              stall,
    output logic              squash_slot
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            kill;
    } state_t;

    state_t state_d, state_q;

    bkind_e          kind;
    logic            live;
    logic            is_cond;
    logic            take;
    logic            guess_miss;
    logic            hold;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;

    assign kind = bkind_e'(id_kind);

    brnext_cond #(.XLEN(XLEN)) u_cond (
        .kind       (kind),
        .src_val    (id_src_val),
        .cancel     (id_cancel),
        .pred_taken (id_pred_taken),
        .take       (take),
        .guess_miss (guess_miss)
    );

    brnext_target #(.XLEN(XLEN), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_target (
        .id_pc      (id_pc),
        .imm        (id_imm),
        .off        (id_off),
        .br_target  (br_target),
        .jmp_target (jmp_target)
    );

    brnext_hazard #(.RIDX_W(RIDX_W)) u_hazard (
        .is_cond   (is_cond),
        .src_idx   (id_src_idx),
        .ex_wr_en  (ex_wr_en),
        .ex_wr_idx (ex_wr_idx),
        .hold      (hold)
    );

    always_comb begin
        live    = id_valid && !state_q.kill;
        is_cond = live && (kind == K_BEQZ || kind == K_BNEZ);

        state_d      = state_q;
        state_d.kill = 1'b0;
        if (hold) begin
            state_d.pc = state_q.pc;
        end else if (live && kind == K_JUMP) begin
            state_d.pc = jmp_target;
        end else if (is_cond && take) begin
            state_d.pc = br_target;
        end else begin
            state_d.pc = state_q.pc + STEP;
        end
        if (is_cond && !hold && guess_miss) begin
            state_d.kill = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pc   <= RESET_PC;
            state_q.kill <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fetch_pc    = state_q.pc;
    assign squash_slot = state_q.kill;
    assign stall       = hold;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (fetch_pc == $past(fetch_pc)));

    // R8
    stall_nokill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !squash_slot);

    // R7
    kill_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_slot |-> $past(id_cancel && id_valid));

    // R5
    jump_nokill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_kind == 2'b11) |-> (!stall ##1 !squash_slot));

    // R10
    idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |=> (fetch_pc == $past(fetch_pc) + STEP));

    // R9
    killed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_slot |-> !stall);
endmodule

// File: tb/brnext_unit_test.sv
module brnext_unit_test;
    localparam logic [31:0] RPC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_valid;
    logic [31:0] id_pc;
    logic [1:0]  id_kind;
    logic        id_cancel;
    logic        id_pred_taken;
    logic [4:0]  id_src_idx;
    logic [31:0] id_src_val;
    logic [15:0] id_imm;
    logic [25:0] id_off;
    logic        ex_wr_en;
    logic [4:0]  ex_wr_idx;
    logic [31:0] fetch_pc;
    logic        stall;
    logic        squash_slot;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mpc;

    always #10 clk = ~clk;

    brnext_unit #(.RESET_PC(RPC)) uut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_pc(id_pc),
        .id_kind(id_kind), .id_cancel(id_cancel), .id_pred_taken(id_pred_taken),
        .id_src_idx(id_src_idx), .id_src_val(id_src_val), .id_imm(id_imm),
        .id_off(id_off), .ex_wr_en(ex_wr_en), .ex_wr_idx(ex_wr_idx),
        .fetch_pc(fetch_pc), .stall(stall), .squash_slot(squash_slot)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic        cancel;
        logic        pred;
        logic [31:0] val;
        logic [15:0] imm;
        logic [25:0] off;
        logic        redirect;
        logic        kill;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b0, 1'b0, 32'd0, 16'h0040, 26'd0,         1'b0, 1'b0},
        '{2'd1, 1'b0, 1'b0, 32'd0, 16'h0010, 26'd0,         1'b1, 1'b0},
        '{2'd1, 1'b0, 1'b1, 32'd5, 16'h0010, 26'd0,         1'b0, 1'b0},
        '{2'd2, 1'b0, 1'b0, 32'd5, 16'hFFF0, 26'd0,         1'b1, 1'b0},
        '{2'd2, 1'b0, 1'b1, 32'd0, 16'h0020, 26'd0,         1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b1, 32'd0, 16'h0030, 26'd0,         1'b1, 1'b0},
        '{2'd1, 1'b1, 1'b0, 32'd0, 16'h0030, 26'd0,         1'b1, 1'b1},
        '{2'd2, 1'b1, 1'b1, 32'd0, 16'h0030, 26'd0,         1'b0, 1'b1},
        '{2'd2, 1'b1, 1'b0, 32'd0, 16'h0030, 26'd0,         1'b0, 1'b0},
        '{2'd3, 1'b1, 1'b0, 32'd9, 16'h0000, 26'h0000200,   1'b1, 1'b0},
        '{2'd3, 1'b0, 1'b0, 32'd0, 16'h0000, 26'h3FFFFF8,   1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] k, input logic c, input logic p,
                         input logic [4:0] si, input logic [31:0] sv,
                         input logic [15:0] im, input logic [25:0] of,
                         input logic we, input logic [4:0] wi);
        id_valid = v; id_pc = mpc - 32'd4; id_kind = k; id_cancel = c;
        id_pred_taken = p; id_src_idx = si; id_src_val = sv; id_imm = im;
        id_off = of; ex_wr_en = we; ex_wr_idx = wi;
    endtask

    task automatic idle();
        drive(1'b0, 2'd0, 1'b0, 1'b0, 5'd0, 32'd0, 16'd0, 26'd0, 1'b0, 5'd0);
    endtask

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] sx26(input logic [25:0] v);
        return {{6{v[25]}}, v};
    endfunction

    initial begin
        #(20 * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        mpc = RPC;
        rst_n = 1'b0;
        idle();
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pc", fetch_pc, RPC);
        chk("R1 reset squash", {31'd0, squash_slot}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        mpc = mpc + 32'd4;
        chk("R2 sequential", fetch_pc, mpc);

        for (int i = 0; i < NV; i++) begin
            string tag;
            logic [31:0] tgt;
            tag = (TBL[i].kind == 2'd3) ? "R5" :
                  TBL[i].imm[15]        ? "R4" :
                  TBL[i].cancel         ? "R7" :
                  (TBL[i].kind == 2'd0) ? "R2" : "R3 R6";
            @(negedge clk);
            drive(1'b1, TBL[i].kind, TBL[i].cancel, TBL[i].pred, 5'd4, TBL[i].val,
                  TBL[i].imm, TBL[i].off, 1'b0, 5'd0);
            #1 chk({tag, " no stall"}, {31'd0, stall}, 32'd0);
            tgt = (TBL[i].kind == 2'd3) ? mpc + sx26(TBL[i].off) : mpc + sx16(TBL[i].imm);
            @(posedge clk); #1;
            mpc = TBL[i].redirect ? tgt : mpc + 32'd4;
            chk({tag, " next pc"}, fetch_pc, mpc);
            chk({tag, " squash"}, {31'd0, squash_slot}, {31'd0, TBL[i].kill});
            @(negedge clk);
            idle();
            @(posedge clk); #1;
            mpc = mpc + 32'd4;
            chk("R2 after vector", fetch_pc, mpc);
            chk("R7 squash one cycle", {31'd0, squash_slot}, 32'd0);
        end

        // R8: tested register produced by execute
        @(negedge clk);
        drive(1'b1, 2'd1, 1'b1, 1'b0, 5'd7, 32'd0, 16'h0020, 26'd0, 1'b1, 5'd7);
        #1 chk("R8 stall raised", {31'd0, stall}, 32'd1);
        @(posedge clk); #1;
        chk("R8 pc held", fetch_pc, mpc);
        chk("R8 no squash during stall", {31'd0, squash_slot}, 32'd0);
        @(negedge clk);
        drive(1'b1, 2'd1, 1'b1, 1'b0, 5'd7, 32'd0, 16'h0020, 26'd0, 1'b0, 5'd0);
        #1 chk("R8 stall cleared", {31'd0, stall}, 32'd0);
        @(posedge clk); #1;
        mpc = mpc + 32'h20;
        chk("R8 branch after stall", fetch_pc, mpc);
        chk("R8 squash after stall", {31'd0, squash_slot}, 32'd1);
        @(negedge clk);
        idle();
        @(posedge clk); #1;
        mpc = mpc + 32'd4;

        // R8: register zero never stalls
        @(negedge clk);
        drive(1'b1, 2'd1, 1'b0, 1'b0, 5'd0, 32'd5, 16'h0020, 26'd0, 1'b1, 5'd0);
        #1 chk("R8 reg zero no stall", {31'd0, stall}, 32'd0);
        @(posedge clk); #1;
        mpc = mpc + 32'd4;
        chk("R8 reg zero not taken", fetch_pc, mpc);

        // R5: jump ignores a pending write
        @(negedge clk);
        drive(1'b1, 2'd3, 1'b0, 1'b0, 5'd3, 32'd0, 16'd0, 26'h0000100, 1'b1, 5'd3);
        #1 chk("R5 jump no stall", {31'd0, stall}, 32'd0);
        @(posedge clk); #1;
        mpc = mpc + 32'h100;
        chk("R5 jump target", fetch_pc, mpc);

        // R9: slot of a wrong guess is ignored
        @(negedge clk);
        drive(1'b1, 2'd1, 1'b1, 1'b0, 5'd4, 32'd0, 16'h0040, 26'd0, 1'b0, 5'd0);
        @(posedge clk); #1;
        mpc = mpc + 32'h40;
        chk("R9 setup squash", {31'd0, squash_slot}, 32'd1);
        @(negedge clk);
        drive(1'b1, 2'd1, 1'b1, 1'b0, 5'd6, 32'd0, 16'h0100, 26'd0, 1'b1, 5'd6);
        #1 chk("R9 killed no stall", {31'd0, stall}, 32'd0);
        @(posedge clk); #1;
        mpc = mpc + 32'd4;
        chk("R9 killed no redirect", fetch_pc, mpc);
        chk("R9 killed no squash", {31'd0, squash_slot}, 32'd0);

        // R10: invalid decode slot
        @(negedge clk);
        drive(1'b0, 2'd1, 1'b1, 1'b0, 5'd4, 32'd0, 16'h0100, 26'd0, 1'b1, 5'd4);
        #1 chk("R10 invalid no stall", {31'd0, stall}, 32'd0);
        @(posedge clk); #1;
        mpc = mpc + 32'd4;
        chk("R10 invalid no redirect", fetch_pc, mpc);
        chk("R10 invalid no squash", {31'd0, squash_slot}, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule